// File: doc/BRIEF.md
# Card Window Address Decoder

This block sits between a host bus and a removable-card socket controller and decides, for every host access, which of eight programmable card windows the address falls into. Each window is described by a base register and an option register. The option register gives the window size as a 5-bit code, a valid flag, a write-protect flag, the socket the window belongs to, the address space the access goes to (common memory, attribute memory or I/O), the port width, and three strobe timing fields counted in bus clocks.

There is no offset register. A window therefore covers a naturally aligned power-of-two block starting at its base, and the card address is the host address minus that base. When several valid windows cover the same address, the lowest-numbered one wins. A window whose size code is reserved never matches. An access that hits no window raises a miss. A write into a write-protected window raises an error and is not forwarded.

Configuration arrives over a simple write port. Results for an access are registered and appear one clock after the access is presented, together with the decoded attributes the strobe generator downstream needs.

Top module: `card_window_decoder`

## Requirements
- R1: After reset every window is invalid and all result outputs are zero, so any access then reports a miss.
- R2: `cfg_sel` addresses the register file as window index times two, plus 0 for the base register or 1 for the option register. A write takes effect for accesses presented in the following cycle and later. An access presented in the same cycle as the write sees the old contents.
- R3: The option register bits 31:27 hold the size code. Codes 0..7 give 1, 2, 8, 4, 128, 64, 16 and 32 bytes. Codes 8..15 give 32K, 16K, 4K, 8K, 256, 512, 2K and 1K bytes. Codes 20, 21 and 23 give 16M, 32M and 64M bytes. Codes 24..31 give 64K, 128K, 512K, 256K, 8M, 4M, 1M and 2M bytes.
- R4: Size codes 16, 17, 18, 19 and 22 are reserved, and a window carrying one of them never matches.
- R5: A window matches when option bit 0 (valid) is 1 and (address AND NOT(size-1)) equals the base. A base with bits set below the size boundary therefore never matches.
- R6: When several windows match, the lowest-numbered one is reported in `res_win`.
- R7: On a hit, the outputs carry fields of the winning option register. The socket comes from bit 2 and the 16-bit port flag from bit 6. The space comes from bits 4:3, where 00 is common memory, 10 is attribute memory and 11 is I/O. The strobe length comes from bits 11:7, the setup time from bits 15:12 and the hold time from bits 19:16.
- R8: On a hit, `res_card_addr` equals the host address minus the winning window's base.
- R9: A write that hits a window whose option bit 1 (write-protect) is set gives `res_err`=1 and `res_fwd`=0. Any other hit gives `res_fwd`=1 and `res_err`=0.
- R10: An access that matches no window gives `res_miss`=1. In that case `res_hit`, `res_err` and `res_fwd` are 0, and the window index, attribute fields and card address are all zero.
- R11: The results of an access appear with `res_valid`=1 exactly one cycle after `acc_valid`. In a cycle after no access, `res_valid`, `res_hit` and `res_miss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select: {window index, 0 base / 1 option} |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Host access present |
| acc_write | input | 1 | Host access is a write |
| acc_addr | input | 32 | Host address |
| res_valid | output | 1 | Result of the previous cycle's access |
| res_hit | output | 1 | Some window matched |
| res_miss | output | 1 | No window matched |
| res_err | output | 1 | Write to a write-protected window |
| res_fwd | output | 1 | Access forwarded to the card |
| res_win | output | 3 | Winning window index |
| res_socket | output | 1 | Socket of the winning window |
| res_space | output | 2 | Address space of the access |
| res_wide | output | 1 | 16-bit port |
| res_strobe | output | 5 | Strobe length in bus clocks |
| res_setup | output | 4 | Setup time in bus clocks |
| res_hold | output | 4 | Hold time in bus clocks |
| res_card_addr | output | 32 | Address inside the card window |

## Verification
Every result of an access lands exactly one clock after the access: hit, miss, error, forward, window index, attributes and card address all come from one output register stage. The bench drives each access on a falling edge, removes it on the next falling edge, and samples all outputs at that same falling edge, after the one rising edge that loads the result. A register write is likewise seen only from the cycle after its rising edge. The bench tests this directly by presenting an access together with a write and expecting the old outcome, then repeating the access one cycle later and expecting the new outcome.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int ADDR_W = 32;
    localparam int CODE_W = 5;
    localparam int EXP_W  = 5;

    typedef enum logic [1:0] {
        SPC_COMMON = 2'b00,
        SPC_RSVD   = 2'b01,
        SPC_ATTR   = 2'b10,
        SPC_IO     = 2'b11
    } space_e;

    // Option register layout; field positions are decoded downstream.
    typedef struct packed {
        logic [CODE_W-1:0] size_code;  // 31:27
        logic [6:0]        spare_hi;   // 26:20
        logic [3:0]        hold;       // 19:16
        logic [3:0]        setup;      // 15:12
        logic [4:0]        strobe;     // 11:7
        logic              wide;       // 6
        logic              spare_lo;   // 5
        space_e            space;      // 4:3
        logic              socket;     // 2
        logic              wprot;      // 1
        logic              valid;      // 0
    } win_opt_t;

    typedef struct packed {
        logic             ok;
        logic [EXP_W-1:0] expo;
    } size_dec_t;

    typedef struct packed {
        logic       hit;
        logic       miss;
        logic       err;
        logic       fwd;
        logic       socket;
        space_e     space;
        logic       wide;
        logic [4:0] strobe;
        logic [3:0] setup;
        logic [3:0] hold;
    } acc_res_t;

    // Scrambled size code to log2(bytes)
    function automatic size_dec_t decode_size(input logic [CODE_W-1:0] code);
        size_dec_t d;
        d.ok = 1'b1;
        unique case (code)
            5'd0:  d.expo = 5'd0;
            5'd1:  d.expo = 5'd1;
            5'd2:  d.expo = 5'd3;
            5'd3:  d.expo = 5'd2;
            5'd4:  d.expo = 5'd7;
            5'd5:  d.expo = 5'd6;
            5'd6:  d.expo = 5'd4;
            5'd7:  d.expo = 5'd5;
            5'd8:  d.expo = 5'd15;
            5'd9:  d.expo = 5'd14;
            5'd10: d.expo = 5'd12;
            5'd11: d.expo = 5'd13;
            5'd12: d.expo = 5'd8;
            5'd13: d.expo = 5'd9;
            5'd14: d.expo = 5'd11;
            5'd15: d.expo = 5'd10;
            5'd20: d.expo = 5'd24;
            5'd21: d.expo = 5'd25;
            5'd23: d.expo = 5'd26;
            5'd24: d.expo = 5'd16;
            5'd25: d.expo = 5'd17;
            5'd26: d.expo = 5'd19;
            5'd27: d.expo = 5'd18;
            5'd28: d.expo = 5'd23;
            5'd29: d.expo = 5'd22;
            5'd30: d.expo = 5'd20;
            5'd31: d.expo = 5'd21;
            default: begin
                d.ok   = 1'b0;
                d.expo = '0;
            end
        endcase
        return d;
    endfunction

    function automatic logic [ADDR_W-1:0] low_mask(input logic [EXP_W-1:0] expo);
        return (ADDR_W'(1) << expo) - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
    import cwd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int SEL_W  = IDX_W + 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [SEL_W-1:0]                  cfg_sel,
    input  logic [ADDR_W-1:0]                 cfg_wdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]    base_q,
    output win_opt_t [NUM_WIN-1:0]            opt_q
);

    logic [IDX_W-1:0] wr_idx;
    logic             wr_is_opt;

    assign wr_idx    = cfg_sel[SEL_W-1:1];
    assign wr_is_opt = cfg_sel[0];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[w] <= '0;
                opt_q[w]  <= '0;
            end else if (cfg_we && (wr_idx == IDX_W'(w))) begin
                if (wr_is_opt) begin
                    opt_q[w] <= win_opt_t'(cfg_wdata);
                end else begin
                    base_q[w] <= cfg_wdata;
                end
            end
        end
    end

endmodule

// File: rtl/cwd_win_match.sv
module cwd_win_match
    import cwd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [CODE_W-1:0] size_code,
    input  logic              valid,
    output logic              match,
    output logic [ADDR_W-1:0] offset
);

    size_dec_t        dec;
    logic [ADDR_W-1:0] mask;

    always_comb begin
        dec    = decode_size(size_code);
        mask   = low_mask(dec.expo);
        match  = valid && dec.ok && ((addr & ~mask) == base);
        offset = addr & mask;
    end

endmodule

// File: rtl/cwd_prio_sel.sv
module cwd_prio_sel #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/card_window_decoder.sv
module card_window_decoder
    import cwd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int SEL_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [31:0]       acc_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_err,
    output logic              res_fwd,
    output logic [IDX_W-1:0]  res_win,
    output logic              res_socket,
    output logic [1:0]        res_space,
    output logic              res_wide,
    output logic [4:0]        res_strobe,
    output logic [3:0]        res_setup,
    output logic [3:0]        res_hold,
    output logic [31:0]       res_card_addr
);

    logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
    win_opt_t [NUM_WIN-1:0]         opt_q;
    logic [NUM_WIN-1:0]             match_vec;
    logic [NUM_WIN-1:0][ADDR_W-1:0] offset_vec;
    logic                           any_match;
    logic [IDX_W-1:0]               win_idx;

    cwd_regfile #(.NUM_WIN(NUM_WIN)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .opt_q     (opt_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        cwd_win_match cmp_i (
            .addr      (acc_addr),
            .base      (base_q[w]),
            .size_code (opt_q[w].size_code),
            .valid     (opt_q[w].valid),
            .match     (match_vec[w]),
            .offset    (offset_vec[w])
        );
    end

    cwd_prio_sel #(.N(NUM_WIN)) prio_i (
        .req (match_vec),
        .any (any_match),
        .idx (win_idx)
    );

    win_opt_t         sel_opt;
    acc_res_t         nxt;
    logic [ADDR_W-1:0] nxt_card;
    logic [IDX_W-1:0] nxt_win;

    always_comb begin
        sel_opt  = opt_q[win_idx];
        nxt      = '0;
        nxt_card = '0;
        nxt_win  = '0;
        if (acc_valid) begin
            if (any_match) begin
                nxt.hit    = 1'b1;
                nxt.err    = acc_write && sel_opt.wprot;
                nxt.fwd    = !(acc_write && sel_opt.wprot);
                nxt.socket = sel_opt.socket;
                nxt.space  = sel_opt.space;
                nxt.wide   = sel_opt.wide;
                nxt.strobe = sel_opt.strobe;
                nxt.setup  = sel_opt.setup;
                nxt.hold   = sel_opt.hold;
                nxt_card   = offset_vec[win_idx];
                nxt_win    = win_idx;
            end else begin
                nxt.miss = 1'b1;
            end
        end
    end

    logic unused_spare;
    assign unused_spare = ^{sel_opt.spare_hi, sel_opt.spare_lo};

    acc_res_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid     <= 1'b0;
            res_q         <= '0;
            res_win       <= '0;
            res_card_addr <= '0;
        end else begin
            res_valid     <= acc_valid;
            res_q         <= nxt;
            res_win       <= nxt_win;
            res_card_addr <= nxt_card;
        end
    end

    assign res_hit    = res_q.hit;
    assign res_miss   = res_q.miss;
    assign res_err    = res_q.err;
    assign res_fwd    = res_q.fwd;
    assign res_socket = res_q.socket;
    assign res_space  = res_q.space;
    assign res_wide   = res_q.wide;
    assign res_strobe = res_q.strobe;
    assign res_setup  = res_q.setup;
    assign res_hold   = res_q.hold;

endmodule

// File: rtl/cwd_chk.sv
module cwd_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_miss,
    input logic             res_err,
    input logic             res_fwd,
    input logic [IDX_W-1:0] res_win,
    input logic [31:0]      res_card_addr
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !res_hit && !res_miss));

    assert_access_latency_R11: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);

    assert_idle_latency_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !res_valid);

    assert_single_outcome_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_hit, res_miss}) && (res_valid == (res_hit || res_miss)));

    assert_err_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
        res_err |-> (res_hit && $past(acc_write)));

    assert_hit_disposition_R9: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (res_fwd != res_err));

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (rst)
        res_miss |-> (!res_err && !res_fwd && res_win == '0 && res_card_addr == '0));

endmodule

bind card_window_decoder cwd_chk #(.IDX_W(IDX_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .res_valid     (res_valid),
    .res_hit       (res_hit),
    .res_miss      (res_miss),
    .res_err       (res_err),
    .res_fwd       (res_fwd),
    .res_win       (res_win),
    .res_card_addr (res_card_addr)
);

// File: tb/card_window_decoder_tb_top.sv
module card_window_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        res_valid, res_hit, res_miss, res_err, res_fwd;
    logic [2:0]  res_win;
    logic        res_socket, res_wide;
    logic [1:0]  res_space;
    logic [4:0]  res_strobe;
    logic [3:0]  res_setup, res_hold;
    logic [31:0] res_card_addr;

    always #2 clk = ~clk;

    card_window_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_err(res_err),
        .res_fwd(res_fwd), .res_win(res_win), .res_socket(res_socket), .res_space(res_space),
        .res_wide(res_wide), .res_strobe(res_strobe), .res_setup(res_setup),
        .res_hold(res_hold), .res_card_addr(res_card_addr)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] tb_base [8];
    logic [31:0] tb_opt  [8];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_opt(input logic [4:0] code, input logic [3:0] hold,
        input logic [3:0] setup, input logic [4:0] strobe, input logic wide,
        input logic [1:0] space, input logic sock, input logic wp, input logic vld);
        return {code, 7'd0, hold, setup, strobe, wide, 1'b0, space, sock, wp, vld};
    endfunction

    // Sizes per R3; 0 marks the reserved codes of R4
    function automatic logic [31:0] size_bytes(input int code);
        case (code)
            0: return 1;       1: return 2;       2: return 8;       3: return 4;
            4: return 128;     5: return 64;      6: return 16;      7: return 32;
            8: return 32768;   9: return 16384;   10: return 4096;   11: return 8192;
            12: return 256;    13: return 512;    14: return 2048;   15: return 1024;
            20: return 32'h0100_0000; 21: return 32'h0200_0000; 23: return 32'h0400_0000;
            24: return 32'h0001_0000; 25: return 32'h0002_0000; 26: return 32'h0008_0000;
            27: return 32'h0004_0000; 28: return 32'h0080_0000; 29: return 32'h0040_0000;
            30: return 32'h0010_0000; 31: return 32'h0020_0000;
            default: return 0;
        endcase
    endfunction

    task automatic wr_cfg(input int w, input bit is_opt, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = {3'(w), is_opt}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (is_opt) tb_opt[w] = d; else tb_base[w] = d;
    endtask

    // Compare the sampled outputs with the expectation for window w (15 = miss)
    task automatic expect_res(input logic [31:0] a, input bit wr, input logic [3:0] w, input string tag);
        logic [23:0] exp_v, act_v;
        logic [31:0] o, exp_card;
        bit          miss;
        miss = (w == 4'hF);
        o = miss ? 32'd0 : tb_opt[w[2:0]];
        exp_card = miss ? 32'd0 : (a - tb_base[w[2:0]]);
        exp_v = {!miss, miss, !miss && wr && o[1], !miss && !(wr && o[1]),
                 miss ? 3'd0 : w[2:0], o[2], o[4:3], o[6], o[11:7], o[15:12], o[19:16]};
        act_v = {res_hit, res_miss, res_err, res_fwd, res_win, res_socket, res_space,
                 res_wide, res_strobe, res_setup, res_hold};
        check(res_valid && act_v == exp_v, tag, {40'd0, res_valid, act_v[22:0]}, {40'd0, 1'b1, exp_v[22:0]});
        check(res_card_addr == exp_card, {tag, " R8 card address"}, {32'd0, res_card_addr}, {32'd0, exp_card});
    endtask

    task automatic access(input logic [31:0] a, input bit wr, input logic [3:0] w, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        expect_res(a, wr, w, tag);
    endtask

    // {address, write, expected window (F = miss)}
    localparam logic [36:0] VECS [14] = '{
        {32'h4000_0000, 1'b0, 4'h0},
        {32'h4000_7FFF, 1'b1, 4'h0},
        {32'h4000_8000, 1'b0, 4'hF},
        {32'h2000_1234, 1'b0, 4'h1},
        {32'h23FF_FFFF, 1'b1, 4'h1},
        {32'h2400_0000, 1'b0, 4'hF},
        {32'h5000_0000, 1'b0, 4'hF},
        {32'h6000_0003, 1'b1, 4'h4},
        {32'h6000_0004, 1'b0, 4'hF},
        {32'h7000_0000, 1'b1, 4'h5},
        {32'h7000_0001, 1'b0, 4'hF},
        {32'h3000_0010, 1'b0, 4'hF},
        {32'h8000_0004, 1'b0, 4'hF},
        {32'h5000_0000, 1'b1, 4'hF}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin tb_base[i] = '0; tb_opt[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!res_valid && !res_hit && !res_miss && res_card_addr == 0, "R1 reset outputs",
              {32'd0, res_card_addr}, 64'd0);
        access(32'h0000_0000, 1'b0, 4'hF, "R1 access after reset misses");

        wr_cfg(0, 0, 32'h4000_0000); wr_cfg(0, 1, mk_opt(5'd8, 4'd2, 4'd1, 5'd7, 1'b0, 2'b10, 1'b1, 1'b1, 1'b1));
        wr_cfg(1, 0, 32'h2000_0000); wr_cfg(1, 1, mk_opt(5'd23, 4'd5, 4'd4, 5'd20, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1));
        wr_cfg(2, 0, 32'h2000_0000); wr_cfg(2, 1, mk_opt(5'd24, 4'd1, 4'd1, 5'd3, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1));
        wr_cfg(3, 0, 32'h5000_0000); wr_cfg(3, 1, mk_opt(5'd19, 4'd1, 4'd1, 5'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
        wr_cfg(4, 0, 32'h6000_0000); wr_cfg(4, 1, mk_opt(5'd3, 4'd3, 4'd2, 5'd9, 1'b0, 2'b11, 1'b1, 1'b0, 1'b1));
        wr_cfg(5, 0, 32'h7000_0000); wr_cfg(5, 1, mk_opt(5'd0, 4'd0, 4'd0, 5'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
        wr_cfg(6, 0, 32'h3000_0000); wr_cfg(6, 1, mk_opt(5'd4, 4'd1, 4'd1, 5'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0));
        wr_cfg(7, 0, 32'h8000_0004); wr_cfg(7, 1, mk_opt(5'd2, 4'd1, 4'd1, 5'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));

        for (int v = 0; v < 14; v++) begin
            access(VECS[v][36:5], VECS[v][4], VECS[v][3:0],
                   $sformatf("R5 R6 R7 R9 R10 vector %0d", v));
        end

        @(negedge clk);
        check(!res_valid && !res_hit && !res_miss, "R11 idle cycle has no result",
              {61'd0, res_valid, res_hit, res_miss}, 64'd0);

        // R6: with window 1 off, the overlapped window 2 takes over
        wr_cfg(1, 1, tb_opt[1] & 32'hFFFF_FFFE);
        access(32'h2000_1234, 1'b0, 4'h2, "R6 next window after disable");
        access(32'h2001_0000, 1'b0, 4'hF, "R3 beyond 64K window");

        // R3 and R4: sweep every size code on window 6 at base 0
        wr_cfg(6, 0, 32'h0);
        for (int c = 0; c < 32; c++) begin
            wr_cfg(6, 1, mk_opt(5'(c), 4'd2, 4'd3, 5'd4, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1));
            if (size_bytes(c) != 0) begin
                access(size_bytes(c) - 1, 1'b0, 4'h6, $sformatf("R3 code %0d last byte", c));
                access(size_bytes(c), 1'b0, 4'hF, $sformatf("R3 code %0d past end", c));
            end else begin
                access(32'h0, 1'b0, 4'hF, $sformatf("R4 reserved code %0d", c));
            end
        end

        // R2: an access in the same cycle as the write sees the old register
        wr_cfg(6, 1, mk_opt(5'd4, 4'd1, 4'd1, 5'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = {3'd6, 1'b1};
        cfg_wdata = mk_opt(5'd4, 4'd6, 4'd7, 5'd8, 1'b0, 2'b10, 1'b1, 1'b1, 1'b1);
        acc_valid = 1'b1; acc_addr = 32'h10; acc_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        expect_res(32'h10, 1'b0, 4'hF, "R2 same-cycle write not seen");
        tb_opt[6] = mk_opt(5'd4, 4'd6, 4'd7, 5'd8, 1'b0, 2'b10, 1'b1, 1'b1, 1'b1);
        access(32'h10, 1'b1, 4'h6, "R2 R9 write seen next cycle");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule